// File: doc/BRIEF.md
# Floating-Point Final Rounding Stage

This block performs the last step of a floating-point operation. It receives a result that has already been normalized and aligned. The result comes as a sign, a biased exponent and a kept fraction with the hidden bit removed, plus the guard and sticky bits that were shifted out. The block chooses a one-bit increment from a small truth table and adds it at the least significant bit of the joined exponent:fraction field. It returns the packed, rounded word together with inexact and overflow flags.

The four bits that decide rounding are sign, ulp (the LSB of the kept fraction), guard and sticky. These four bits form a 4-bit index into one of several 16-entry tables. A 3-bit mode input picks the table. Every mode uses the same lookup and the same adder, so all modes have the same latency. A carry out of the fraction flows into the exponent on its own. A maximum finite value that rounds up therefore becomes the infinity encoding with no separate adjust path. The output is registered by default. A parameter removes the register and leaves a purely combinational stage.

Top module: `roundUnit`

## Requirements
- R1: Mode code 3'b000 (nearest, ties to even) increments exactly when guard & (sticky | ulp), where ulp is fracIn[0].
- R2: Mode code 3'b001 (toward zero) never increments; the exponent:fraction field is passed through unchanged.
- R3: Mode code 3'b010 (toward +infinity) increments exactly when the sign is 0 and guard | sticky is 1.
- R4: Mode code 3'b011 (toward -infinity) increments exactly when the sign is 1 and guard | sticky is 1.
- R5: Mode code 3'b100 (nearest, ties away from zero) increments exactly when guard is 1.
- R6: Mode codes 3'b101, 3'b110 and 3'b111 behave exactly like 3'b000.
- R7: The increment is added at bit 0 of the packed {exponent, fraction} field, so a fraction of all ones carries into the exponent. The sign bit, at the top of resultOut, is always passed through.
- R8: overflowOut is 1 exactly when a finite input (exponent not all ones) rounds to an all-ones exponent; the result is then the infinity encoding (fraction zero).
- R9: For a finite input, inexactOut equals guard | sticky.
- R10: An input whose exponent is all ones (infinity or NaN) passes through unchanged, with inexactOut and overflowOut both 0.
- R11: With the default REG_OUT=1, outputs reflect the inputs sampled at the previous rising clock edge. An active-low asynchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| signIn | input | 1 | Sign of the unrounded result |
| expIn | input | EXP_W (8) | Biased exponent of the unrounded result |
| fracIn | input | FRAC_W (23) | Kept fraction, hidden bit removed |
| guardIn | input | 1 | First bit below the ulp |
| stickyIn | input | 1 | OR of all bits below the guard |
| modeIn | input | 3 | Rounding mode code |
| resultOut | output | 1+EXP_W+FRAC_W (32) | Rounded packed {sign, exponent, fraction} |
| inexactOut | output | 1 | Rounding discarded nonzero bits |
| overflowOut | output | 1 | Rounding produced infinity from a finite value |

## Verification
If one table entry is stored wrongly, a single combination of mode, sign, ulp, guard and sticky gives a result one ulp off. This shows on resultOut in the first cycle after that combination is sampled. Random stimulus hits each of the 128 mode/index combinations many times. A broken carry path shows only when the fraction is all ones, so fractions of all ones and the largest finite exponent are heavily weighted. A wrong special-value guard corrupts an infinity or NaN in the very next output word.

// File: rtl/round_pkg.sv
package round_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_TO_ZERO   = 3'd1,
    RM_UP        = 3'd2,
    RM_DOWN      = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } roundMode_e;

  // strobes handed from the decision logic to the datapath
  typedef struct packed {
    logic incr;
    logic inexact;
    logic special;
  } rndStrobes_t;

  // Build a 16-entry increment table for one mode code.
  // Index bit 3 = sign, bit 2 = ulp, bit 1 = guard, bit 0 = sticky.
  function automatic logic [15:0] buildTable(input int code);
    logic [15:0] tbl;
    logic s, u, g, k;
    tbl = '0;
    for (int i = 0; i < 16; i++) begin
      s = i[3];
      u = i[2];
      g = i[1];
      k = i[0];
      case (code)
        1:       tbl[i] = 1'b0;
        2:       tbl[i] = ~s & (g | k);
        3:       tbl[i] = s & (g | k);
        4:       tbl[i] = g;
        default: tbl[i] = g & (k | u);
      endcase
    end
    return tbl;
  endfunction

endpackage

// File: rtl/roundCtrl.sv
module roundCtrl
  import round_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MODE_W = 3
) (
  input  logic              signIn,
  input  logic              ulpIn,
  input  logic              guardIn,
  input  logic              stickyIn,
  input  logic [EXP_W-1:0]  expIn,
  input  logic [MODE_W-1:0] modeIn,
  output rndStrobes_t       strobes
);
  localparam int NUM_CODES = 2 ** MODE_W;

  logic [15:0] tblBank [NUM_CODES];

  genvar t;
  generate
    for (t = 0; t < NUM_CODES; t++) begin : g_tbl
      localparam logic [15:0] TBL = buildTable(t);
      assign tblBank[t] = TBL;
    end
  endgenerate

  logic [3:0]  tblIdx;
  logic [15:0] selTbl;
  logic        isSpecial;
  logic        lost;

  always_comb begin
    tblIdx    = {signIn, ulpIn, guardIn, stickyIn};
    selTbl    = tblBank[modeIn];
    isSpecial = &expIn;
    lost      = guardIn | stickyIn;
    strobes.special = isSpecial;
    strobes.incr    = ~isSpecial & selTbl[tblIdx];
    strobes.inexact = ~isSpecial & lost;
  end

endmodule

// File: rtl/roundPath.sv
module roundPath
  import round_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    signIn,
  input  logic [EXP_W-1:0]        expIn,
  input  logic [FRAC_W-1:0]       fracIn,
  input  rndStrobes_t             strobes,
  output logic [EXP_W+FRAC_W:0]   resultOut,
  output logic                    inexactOut,
  output logic                    overflowOut
);
  localparam int MAG_W = EXP_W + FRAC_W;

  logic [MAG_W-1:0] magIn;
  logic [MAG_W-1:0] magSum;
  logic [MAG_W:0]   nextResult;
  logic             nextOverflow;

  always_comb begin
    magIn        = {expIn, fracIn};
    magSum       = magIn + {{(MAG_W-1){1'b0}}, strobes.incr};
    nextResult   = {signIn, magSum};
    nextOverflow = strobes.incr & (&magSum[MAG_W-1:FRAC_W]);
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          resultOut   <= '0;
          inexactOut  <= 1'b0;
          overflowOut <= 1'b0;
        end else begin
          resultOut   <= nextResult;
          inexactOut  <= strobes.inexact;
          overflowOut <= nextOverflow;
        end
      end
    end else begin : g_comb
      assign resultOut   = nextResult;
      assign inexactOut  = strobes.inexact;
      assign overflowOut = nextOverflow;
    end
  endgenerate

endmodule

// File: rtl/roundUnit.sv
module roundUnit
  import round_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  signIn,
  input  logic [EXP_W-1:0]      expIn,
  input  logic [FRAC_W-1:0]     fracIn,
  input  logic                  guardIn,
  input  logic                  stickyIn,
  input  logic [2:0]            modeIn,
  output logic [EXP_W+FRAC_W:0] resultOut,
  output logic                  inexactOut,
  output logic                  overflowOut
);
  rndStrobes_t strobes;

  roundCtrl #(.EXP_W(EXP_W), .MODE_W(3)) u_ctrl (
    .signIn  (signIn),
    .ulpIn   (fracIn[0]),
    .guardIn (guardIn),
    .stickyIn(stickyIn),
    .expIn   (expIn),
    .modeIn  (modeIn),
    .strobes (strobes)
  );

  roundPath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .signIn     (signIn),
    .expIn      (expIn),
    .fracIn     (fracIn),
    .strobes    (strobes),
    .resultOut  (resultOut),
    .inexactOut (inexactOut),
    .overflowOut(overflowOut)
  );

endmodule

// File: rtl/roundUnitChecker.sv
module roundUnitChecker #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  signIn,
  input logic [EXP_W-1:0]      expIn,
  input logic [FRAC_W-1:0]     fracIn,
  input logic                  guardIn,
  input logic                  stickyIn,
  input logic [2:0]            modeIn,
  input logic [EXP_W+FRAC_W:0] resultOut,
  input logic                  inexactOut,
  input logic                  overflowOut
);
  localparam int MAG_W = EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] MAXFIN = {{(EXP_W-1){1'b1}}, 1'b0};

  logic              refValid, refSign, refGuard, refSticky;
  logic [EXP_W-1:0]  refExp;
  logic [FRAC_W-1:0] refFrac;
  logic [2:0]        refMode;

  generate
    if (REG_OUT) begin : g_lag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          refValid <= 1'b0; refSign <= 1'b0; refGuard <= 1'b0; refSticky <= 1'b0;
          refExp <= '0; refFrac <= '0; refMode <= '0;
        end else begin
          refValid <= 1'b1; refSign <= signIn; refGuard <= guardIn; refSticky <= stickyIn;
          refExp <= expIn; refFrac <= fracIn; refMode <= modeIn;
        end
      end
    end else begin : g_now
      assign refValid = 1'b1;
      assign refSign = signIn; assign refGuard = guardIn; assign refSticky = stickyIn;
      assign refExp = expIn; assign refFrac = fracIn; assign refMode = modeIn;
    end
  endgenerate

  logic refSpecial;
  assign refSpecial = &refExp;

  p_rtz_trunc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refMode == 3'd1 && !refSpecial) |-> resultOut[MAG_W-1:0] == {refExp, refFrac});

  p_up_neg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refMode == 3'd2 && refSign && !refSpecial) |-> resultOut[MAG_W-1:0] == {refExp, refFrac});

  p_down_pos_r4: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refMode == 3'd3 && !refSign && !refSpecial) |-> resultOut[MAG_W-1:0] == {refExp, refFrac});

  p_sign_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    refValid |-> resultOut[MAG_W] == refSign);

  p_one_ulp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && !refSpecial) |-> (resultOut[MAG_W-1:0] - {refExp, refFrac}) <= MAG_W'(1));

  p_overflow_inf_r8: assert property (@(posedge clk) disable iff (!rstN)
    overflowOut |-> (&resultOut[MAG_W-1:FRAC_W]) && resultOut[FRAC_W-1:0] == '0);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refExp != MAXFIN) |-> !overflowOut);

  p_inexact_r9: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && !refSpecial) |-> inexactOut == (refGuard | refSticky));

  p_special_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refSpecial) |->
      resultOut == {refSign, refExp, refFrac} && !inexactOut && !overflowOut);

endmodule

bind roundUnit roundUnitChecker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .signIn(signIn), .expIn(expIn), .fracIn(fracIn),
  .guardIn(guardIn), .stickyIn(stickyIn), .modeIn(modeIn),
  .resultOut(resultOut), .inexactOut(inexactOut), .overflowOut(overflowOut)
);

// File: tb/sim_roundUnit.sv
`timescale 1ns/1ps
module sim_roundUnit;
  localparam int EW = 8;
  localparam int FW = 23;
  localparam int W  = 1 + EW + FW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          signIn = 1'b0;
  logic [EW-1:0] expIn = '0;
  logic [FW-1:0] fracIn = '0;
  logic          guardIn = 1'b0;
  logic          stickyIn = 1'b0;
  logic [2:0]    modeIn = '0;
  logic [W-1:0]  resultOut;
  logic          inexactOut;
  logic          overflowOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  roundUnit u0 (
    .clk(clk), .rstN(rstN), .signIn(signIn), .expIn(expIn), .fracIn(fracIn),
    .guardIn(guardIn), .stickyIn(stickyIn), .modeIn(modeIn),
    .resultOut(resultOut), .inexactOut(inexactOut), .overflowOut(overflowOut)
  );

  // reference model from the requirements: returns {result, inexact, overflow}
  function automatic logic [W+1:0] model(input logic s, input logic [EW-1:0] e,
      input logic [FW-1:0] f, input logic g, input logic k, input logic [2:0] m);
    logic inc;
    logic [EW+FW-1:0] mag;
    logic [EW+FW:0] wide;
    if (&e) return {s, e, f, 1'b0, 1'b0};
    case (m)
      3'd1: inc = 1'b0;
      3'd2: inc = !s && (g || k);
      3'd3: inc = s && (g || k);
      3'd4: inc = g;
      default: inc = g && (k || f[0]);
    endcase
    wide = {1'b0, e, f} + inc;
    mag = wide[EW+FW-1:0];
    return {s, mag, g | k, (inc && (&mag[EW+FW-1:FW]))};
  endfunction

  function automatic string tagFor(input logic [EW-1:0] e, input logic [2:0] m);
    if (&e) return "R10";
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic s, input logic [EW-1:0] e, input logic [FW-1:0] f,
      input logic g, input logic k, input logic [2:0] m, input string tag);
    logic [W+1:0] exp;
    @(negedge clk);
    signIn = s; expIn = e; fracIn = f; guardIn = g; stickyIn = k; modeIn = m;
    exp = model(s, e, f, g, k, m);
    @(negedge clk);   // one rising edge has captured the inputs (R11)
    checks++;
    if ({resultOut, inexactOut, overflowOut} !== exp) begin
      errors++;
      $display("FAIL %s (R7 R8 R9 R11): got res=%h inx=%b ovf=%b expected res=%h inx=%b ovf=%b",
               tag, resultOut, inexactOut, overflowOut, exp[W+1:2], exp[1], exp[0]);
    end
  endtask

  localparam logic [FW-1:0] FONES = '1;

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20211));
    repeat (3) @(negedge clk);
    checks++;   // R11 reset state
    if ({resultOut, inexactOut, overflowOut} !== '0) begin
      errors++;
      $display("FAIL R11: got %h expected 0", {resultOut, inexactOut, overflowOut});
    end
    rstN = 1'b1;

    apply(0, 8'd100, 23'h000010, 1, 0, 3'd0, "R1 tie even kept");
    apply(0, 8'd100, 23'h000011, 1, 0, 3'd0, "R1 tie odd up");
    apply(1, 8'd100, 23'h000011, 1, 1, 3'd1, "R2 truncate");
    apply(0, 8'd20,  23'h000000, 0, 1, 3'd2, "R3 positive up");
    apply(1, 8'd20,  23'h000000, 0, 1, 3'd2, "R3 negative kept");
    apply(1, 8'd20,  23'h000000, 0, 1, 3'd3, "R4 negative up");
    apply(0, 8'd20,  23'h000002, 1, 0, 3'd4, "R5 tie away");
    apply(0, 8'd20,  23'h000003, 1, 0, 3'd7, "R6 code 7");
    apply(0, 8'd20,  23'h000002, 1, 0, 3'd5, "R6 code 5");
    apply(0, 8'd5,   FONES,      1, 1, 3'd0, "R7 fraction carry");
    apply(0, 8'd254, FONES,      1, 0, 3'd2, "R8 to infinity");
    apply(1, 8'd254, FONES,      0, 1, 3'd3, "R8 negative to infinity");
    apply(0, 8'd254, FONES,      1, 1, 3'd1, "R8 saturate no overflow");
    apply(0, 8'd77,  23'h123456, 0, 0, 3'd0, "R9 exact");
    apply(0, 8'd255, 23'h000001, 1, 1, 3'd4, "R10 NaN pass");
    apply(1, 8'd255, 23'h000000, 1, 0, 3'd3, "R10 infinity pass");
    apply(0, 8'd0,   FONES,      1, 1, 3'd0, "R7 subnormal to normal");

    for (int n = 0; n < 3000; n++) begin
      logic [EW-1:0] e;
      logic [FW-1:0] f;
      logic [2:0] m;
      int pick;
      pick = $urandom % 16;
      e = (pick < 2) ? 8'd254 : (pick == 2) ? 8'd255 : EW'($urandom);
      f = (($urandom % 4) == 0) ? FONES : FW'($urandom);
      m = 3'($urandom);
      apply(1'($urandom), e, f, 1'($urandom), 1'($urandom), m, tagFor(e, m));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule